// File: doc/BRIEF.md
# Three-Channel PWM Brightness Generator

This block turns three held 10-bit brightness codes into three digital on/off channel enables by comparing each code against one shared 10-bit PWM counter. It is the timing core of a colour LED pixel driver: software or a serial front end holds the brightness codes stable, and this block decides, cycle by cycle, whether each channel's current sink should conduct. Current scaling and the analog drive stage sit outside it.

The counter steps on a tick whose source is picked by a 2-bit clock-mode input. The tick is either a single-cycle master strobe at full, half or quarter rate (through a small prescaler), or a single-cycle strobe marking a rising edge of an external serial clock. All inputs belong to one system clock domain. An active-low output enable both gates counting and gates the outputs, and its rising edge restarts the PWM period. A thermal fault blanks the outputs only. An undervoltage fault blanks the outputs and holds the counter at zero.

Top module: `pwm_bright_gen`

## Requirements
- R1: The shared counter steps 0,1,...,1023 and wraps to 0; a channel with code n (1 <= n <= 1022) is on exactly while the counter is at most n, giving n+1 on-ticks out of 1024.
- R2: A channel whose code is 0 is never on.
- R3: A channel whose code is 1023 stays on through every counter value, including the wrap from 1023 to 0, whenever outputs are enabled.
- R4: The counter moves by one only in a cycle with a selected tick while `oeN` is low and `uvFault` is low; in every other cycle it keeps its value.
- R5: The counter returns to 0 after reset and in the cycle after `oeN` rises from 0 to 1.
- R6: While `oeN` is 1 all channel outputs are 0.
- R7: `clkMode` 2'b00 ticks on every `masterTick`; 2'b01 ticks only on `extClkEdge` and ignores `masterTick`; 2'b10 ticks on every second `masterTick` and 2'b11 on every fourth, where a 2-bit prescaler counts master strobes from reset and the half rate ticks when its low bit is 1, the quarter rate when both bits are 1.
- R8: While `thermFault` is 1 all outputs are 0, but the counter keeps counting and resumes its pattern when the fault clears.
- R9: While `uvFault` is 1 all outputs are 0 and the counter is held at 0.
- R10: Changing a brightness code takes effect on the next output without restarting the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterTick | input | 1 | One-cycle strobe at the master PWM rate |
| extClkEdge | input | 1 | One-cycle strobe on each external serial clock rising edge |
| clkMode | input | 2 | Tick source: 00 full, 01 external, 10 half, 11 quarter |
| oeN | input | 1 | Active-low output enable; rising edge restarts the period |
| thermFault | input | 1 | Thermal fault, blanks the outputs |
| uvFault | input | 1 | Undervoltage fault, blanks outputs and holds the counter at 0 |
| level | input | 30 | Brightness codes, channel c in bits [10c+9:10c] |
| chanOn | output | 3 | Per-channel on enable |

## Verification
The codes 0, 1, 5, 300, 700 and 1023 are run over complete 1024-step periods, so the forced-off code, the short on-window, mid-range windows and the wrap-through code are each told apart from an off-by-one duty. Every clock mode is run with a master strobe present every cycle, and the external mode also with sparse edge strobes, which separates the divide ratios and shows that the master strobe is ignored in external mode. Enable toggling, thermal and undervoltage episodes are placed mid-period, so that a restart, a frozen count and a running count lead to different later output patterns.

// File: rtl/pwm_bright_pkg.sv
package pwm_bright_pkg;

  typedef struct packed {
    logic advance;    // step the counter this cycle
    logic clear;      // force the counter to zero
    logic outEnable;  // channels may conduct
  } pwmStrobe_t;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'b00,
    MODE_EXT     = 2'b01,
    MODE_HALF    = 2'b10,
    MODE_QUARTER = 2'b11
  } clkMode_e;

endpackage

// File: rtl/pwm_bright_ctrl.sv
module pwm_bright_ctrl
  import pwm_bright_pkg::*;
#(
  parameter int PRE_BITS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterTick,
  input  logic       extClkEdge,
  input  logic [1:0] clkMode,
  input  logic       oeN,
  input  logic       thermFault,
  input  logic       uvFault,
  output pwmStrobe_t strb
);

  logic [PRE_BITS-1:0] preCnt;
  logic                oePrev;
  logic                tickSel;
  logic                oeRise;

  // prescaler counts master strobes since reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           preCnt <= '0;
    else if (masterTick) preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oePrev <= 1'b1;
    else       oePrev <= oeN;
  end

  always_comb begin
    case (clkMode_e'(clkMode))
      MODE_FULL:    tickSel = masterTick;
      MODE_EXT:     tickSel = extClkEdge;
      MODE_HALF:    tickSel = masterTick & preCnt[0];
      MODE_QUARTER: tickSel = masterTick & (&preCnt[1:0]);
      default:      tickSel = 1'b0;
    endcase
  end

  assign oeRise         = oeN & ~oePrev;
  assign strb.clear     = uvFault | oeRise;
  assign strb.advance   = tickSel & ~oeN & ~uvFault;
  assign strb.outEnable = ~oeN & ~thermFault & ~uvFault;

  assert_ext_ignores_master_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode == MODE_EXT && !extClkEdge) |-> !strb.advance);

  assert_quarter_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode == MODE_QUARTER && $past(clkMode) == MODE_QUARTER && strb.advance)
      |=> !strb.advance);

  assert_no_step_when_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (oeN || uvFault) |-> !strb.advance);

endmodule

// File: rtl/pwm_bright_dp.sv
module pwm_bright_dp
  import pwm_bright_pkg::*;
#(
  parameter int CHANNELS = 3,
  parameter int PWM_BITS = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pwmStrobe_t                   strb,
  input  logic [CHANNELS*PWM_BITS-1:0] level,
  output logic [CHANNELS-1:0]          chanOn
);

  localparam logic [PWM_BITS-1:0] LEVEL_FULL = {PWM_BITS{1'b1}};

  logic [PWM_BITS-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.clear)   cnt <= '0;
    else if (strb.advance) cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < CHANNELS; g++) begin : gChan
    logic [PWM_BITS-1:0] lvl;
    assign lvl       = level[g*PWM_BITS +: PWM_BITS];
    assign chanOn[g] = strb.outEnable && (lvl != '0) && (cnt <= lvl);

    assert_full_code_on_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.outEnable && lvl == LEVEL_FULL) |-> chanOn[g]);
  end

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (cnt == '0));

  assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.clear) |=> (cnt == $past(cnt) + 1'b1));

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.clear) |=> $stable(cnt));

endmodule

// File: rtl/pwm_bright_gen.sv
module pwm_bright_gen
  import pwm_bright_pkg::*;
#(
  parameter int CHANNELS = 3,
  parameter int PWM_BITS = 10,
  parameter int PRE_BITS = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         masterTick,
  input  logic                         extClkEdge,
  input  logic [1:0]                   clkMode,
  input  logic                         oeN,
  input  logic                         thermFault,
  input  logic                         uvFault,
  input  logic [CHANNELS*PWM_BITS-1:0] level,
  output logic [CHANNELS-1:0]          chanOn
);

  pwmStrobe_t strb;

  pwm_bright_ctrl #(.PRE_BITS(PRE_BITS)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .masterTick (masterTick),
    .extClkEdge (extClkEdge),
    .clkMode    (clkMode),
    .oeN        (oeN),
    .thermFault (thermFault),
    .uvFault    (uvFault),
    .strb       (strb)
  );

  pwm_bright_dp #(.CHANNELS(CHANNELS), .PWM_BITS(PWM_BITS)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .level  (level),
    .chanOn (chanOn)
  );

  assert_blank_when_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (oeN || thermFault || uvFault) |-> (chanOn == '0));

endmodule

// File: tb/test_pwm_bright_gen.sv
`timescale 1ns/1ps
module test_pwm_bright_gen;

  localparam int CH = 3;
  localparam int PW = 10;

  typedef struct {
    logic [CH-1:0] expOn;
    string         req;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              masterTick = 1'b0;
  logic              extClkEdge = 1'b0;
  logic [1:0]        clkMode = 2'b00;
  logic              oeN = 1'b1;
  logic              thermFault = 1'b0;
  logic              uvFault = 1'b0;
  logic [CH*PW-1:0]  level = '0;
  logic [CH-1:0]     chanOn;

  logic [PW-1:0] lvlReg [CH];
  int            mCnt;
  int            mPre;
  logic          mOePrev;
  item_t         sbQ[$];
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  pwm_bright_gen i_pwm_bright_gen (
    .clk(clk), .rstN(rstN), .masterTick(masterTick), .extClkEdge(extClkEdge),
    .clkMode(clkMode), .oeN(oeN), .thermFault(thermFault), .uvFault(uvFault),
    .level(level), .chanOn(chanOn)
  );

  // driver: one clock of stimulus plus the expected outputs after that edge
  task automatic step(input logic mt, input logic ee, input logic [1:0] md,
                      input logic oe, input logic th, input logic uv, input string req);
    logic tick;
    logic rise;
    item_t it;
    @(negedge clk);
    masterTick = mt; extClkEdge = ee; clkMode = md;
    oeN = oe; thermFault = th; uvFault = uv;
    for (int c = 0; c < CH; c++) level[c*PW +: PW] = lvlReg[c];
    case (md)
      2'b00:   tick = mt;
      2'b01:   tick = ee;
      2'b10:   tick = mt && (mPre % 2 == 1);
      default: tick = mt && (mPre == 3);
    endcase
    rise = oe && !mOePrev;
    if (uv || rise)         mCnt = 0;
    else if (tick && !oe)   mCnt = (mCnt + 1) % 1024;
    if (mt) mPre = (mPre + 1) % 4;
    mOePrev = oe;
    for (int c = 0; c < CH; c++)
      it.expOn[c] = !oe && !th && !uv && (lvlReg[c] != 0) && (mCnt <= int'(lvlReg[c]));
    it.req = req;
    sbQ.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        checks++;
        if (chanOn !== it.expOn) begin
          errors++;
          $display("FAIL %s: chanOn actual %b expected %b at %0t", it.req, chanOn, it.expOn, $time);
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finishRun();
  end

  initial begin
    mCnt = 0; mPre = 0; mOePrev = 1'b1;
    lvlReg[0] = 10'd5; lvlReg[1] = 10'd0; lvlReg[2] = 10'd1023;
    repeat (3) @(posedge clk);
    #2;
    checks++;  // R5 reset state: outputs off
    if (chanOn !== 3'b000) begin
      errors++;
      $display("FAIL R5 reset: chanOn actual %b expected %b", chanOn, 3'b000);
    end
    @(negedge clk);
    rstN = 1'b1;

    // full rate, codes 5/0/1023 over more than one period incl. wrap
    for (int i = 0; i < 1100; i++) step(1, 0, 2'b00, 0, 0, 0, "R1 R2 R3 R7");
    // code change mid-period does not restart the counter
    lvlReg[0] = 10'd700; lvlReg[1] = 10'd1;
    for (int i = 0; i < 1030; i++) step(1, 0, 2'b00, 0, 0, 0, "R10 R1");
    // half rate
    lvlReg[0] = 10'd300;
    for (int i = 0; i < 2100; i++) step(1, 0, 2'b10, 0, 0, 0, "R7 half");
    // quarter rate
    for (int i = 0; i < 1300; i++) step(1, 0, 2'b11, 0, 0, 0, "R7 quarter");
    // external edges only, master strobe present every cycle
    for (int i = 0; i < 900; i++) step(1, (i % 3 == 0), 2'b01, 0, 0, 0, "R7 ext");
    // enable high: blank and frozen, rising edge restarts
    for (int i = 0; i < 20; i++) step(1, 0, 2'b00, 1, 0, 0, "R6 R4");
    for (int i = 0; i < 40; i++) step(1, 0, 2'b00, 0, 0, 0, "R5 restart");
    // enable low but no tick: counter holds
    for (int i = 0; i < 20; i++) step(0, 0, 2'b00, 0, 0, 0, "R4 hold");
    // thermal fault: blank, counter keeps running
    for (int i = 0; i < 30; i++) step(1, 0, 2'b00, 0, 1, 0, "R8 blank");
    for (int i = 0; i < 300; i++) step(1, 0, 2'b00, 0, 0, 0, "R8 resume");
    // undervoltage: blank and held at zero
    for (int i = 0; i < 25; i++) step(1, 0, 2'b00, 0, 0, 1, "R9 blank");
    for (int i = 0; i < 20; i++) step(1, 0, 2'b00, 0, 0, 0, "R9 restart");
    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule